// File: doc/BRIEF.md
# Front-End Hold and Multiplexer Readout Sequencer

This block runs the readout of a front-end chip whose analogue channels are first frozen by a sample-and-hold line and then shifted out one at a time by a multiplexer clock. A trigger starts a sequence. After a programmable wait the block asserts the hold line. It then produces a burst of multiplexer clock pulses with programmable high and low times. After the burst it releases hold and issues a reset pulse of programmable width. The asserted level of the hold line is chosen at run time by a polarity input, and the rest of the sequence is the same for either level.

While the burst runs, the chip returns a shift-register-out marker. The block checks that the marker goes high on the pulse that shifts out the final channel and drops again on the following pulse. To see the marker drop, one extra clock pulse is issued after the last channel. That pulse carries no channel strobe. After each channel's falling clock edge a downstream ADC capture stage receives a one-cycle strobe and a channel index. A busy flag blocks new triggers until the sequence has finished, and a done pulse reports the marker verdict.

Top module: `fe_hold_seq`

## Requirements
- R1: After reset `busy_o`, `muxclk_o`, `vfe_rst_o`, `done_o`, `err_o` and `ch_vld_o` are 0, and `hold_o` equals the inactive level, which is the complement of `hold_pol_i`.
- R2: The hold line is asserted by driving `hold_o` equal to `hold_pol_i` and released by driving it to the complement. Changing `hold_pol_i` changes only the level and leaves the sequence timing unchanged.
- R3: When `busy_o` is 0, a high `trig_i` is accepted and `busy_o` is 1 from the next cycle. A high `trig_i` while `busy_o` is 1 is ignored: it starts no second sequence.
- R4: Hold is asserted D = max(`hold_dly_i`,1) cycles after `busy_o` rises. A low phase of the multiplexer clock comes before each clock pulse.
- R5: While hold is asserted, exactly N_CH+1 (37 by default) multiplexer clock pulses are issued. Each pulse is high for max(`mux_hi_i`,1) cycles, and each pulse is preceded by a low phase of max(`mux_lo_i`,1) cycles. Hold is released in the cycle in which the last pulse falls.
- R6: In the first cycle after the falling edge of each of the first N_CH pulses, `ch_vld_o` is 1 for one cycle, and `ch_idx_o` counts 0 to N_CH-1 in order. The extra final pulse produces no strobe.
- R7: `srout_i` is sampled in the last cycle of each high phase. It must be 1 on pulse N_CH (the 36th) and 0 on every other pulse, including the extra one. Any mismatch sets the reported error.
- R8: `vfe_rst_o` is high for max(`rst_len_i`,1) cycles starting in the cycle hold is released. During that time `muxclk_o` is 0 and hold is inactive.
- R9: In the cycle after the reset pulse ends, `done_o` is 1 for one cycle and `busy_o` is 0. `err_o` takes the verdict of the sequence just finished and keeps it until the next completion. A sequence therefore lasts D + (N_CH+1)·(low+high) + reset cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Readout trigger |
| hold_pol_i | input | 1 | Asserted level of `hold_o` |
| hold_dly_i | input | CNT_W | Trigger to hold delay, in cycles (0 treated as 1) |
| mux_hi_i | input | CNT_W | Multiplexer clock high time, in cycles |
| mux_lo_i | input | CNT_W | Multiplexer clock low time, in cycles |
| rst_len_i | input | CNT_W | Reset pulse width, in cycles |
| srout_i | input | 1 | Shift-register-out marker returned by the chip |
| hold_o | output | 1 | Sample-and-hold control to the chip |
| vfe_rst_o | output | 1 | Reset pulse to the chip |
| muxclk_o | output | 1 | Multiplexer clock to the chip |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Marker check verdict of the last sequence |
| ch_vld_o | output | 1 | Channel sample strobe for the ADC |
| ch_idx_o | output | $clog2(N_CH) | Channel index of the strobe |

## Verification
The hardest situation to reach is a marker that is wrong by one pulse in either direction, or that stays high. A correct chip never produces it, and only the return path reveals it. The bench models the chip and makes the marker follow the clock rising edges it observes. In selected runs it moves the marker one pulse early or late, holds it high, leaves it out entirely, or adds a stray pulse. These runs are interleaved with correct runs, so the verdict is seen both to hold and to clear at completion. All of this runs across a sweep of delays, phase widths, reset widths and both hold polarities.

// File: rtl/fe_seq_pkg.sv
package fe_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_DELAY = 3'd1,
      ST_LOW   = 3'd2,
      ST_HIGH  = 3'd3,
      ST_RST   = 3'd4
   } seq_st_e;

endpackage

// File: rtl/fe_seq_timer.sv
// Shared phase timer: load a length, count it down, flag the final cycle.
module fe_seq_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         last
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (len == '0) ? W'(1) : len;
      end else if (cnt_q > W'(1)) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign last = (cnt_q <= W'(1));

endmodule

// File: rtl/fe_seq_marker.sv
// Accumulates mismatches between the returned marker and its expected pulse.
module fe_seq_marker #(
   parameter int N_CH = 36,
   parameter int PW   = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          smp,
   input  logic [PW-1:0] pidx,
   input  logic          srout_i,
   output logic          err
);

   localparam logic [PW-1:0] MARK_P = PW'(N_CH - 1);

   logic expect_hi;
   assign expect_hi = (pidx == MARK_P);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err <= 1'b0;
      end else if (clr) begin
         err <= 1'b0;
      end else if (smp && (srout_i != expect_hi)) begin
         err <= 1'b1;
      end
   end

endmodule

// File: rtl/fe_hold_seq.sv
module fe_hold_seq
   import fe_seq_pkg::*;
#(
   parameter int N_CH  = 36,
   parameter int CNT_W = 8,
   localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             hold_pol_i,
   input  logic [CNT_W-1:0] hold_dly_i,
   input  logic [CNT_W-1:0] mux_hi_i,
   input  logic [CNT_W-1:0] mux_lo_i,
   input  logic [CNT_W-1:0] rst_len_i,
   input  logic             srout_i,
   output logic             hold_o,
   output logic             vfe_rst_o,
   output logic             muxclk_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic             ch_vld_o,
   output logic [CH_W-1:0]  ch_idx_o
);

   localparam int PW = $clog2(N_CH + 1);
   localparam logic [PW-1:0] LAST_P = PW'(N_CH);

   generate
      if (N_CH < 2) begin : g_bad_nch
         $error("fe_hold_seq: N_CH must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cntw
         $error("fe_hold_seq: CNT_W must be at least 1");
      end
   endgenerate

   seq_st_e          st_q, st_d;
   logic             tmr_ld, tmr_last;
   logic [CNT_W-1:0] tmr_len;
   logic [PW-1:0]    pcnt_q;
   logic             accept, hi_end, mark_err;
   logic             ch_vld_q, done_q, err_q;
   logic [CH_W-1:0]  ch_idx_q;

   assign accept = (st_q == ST_IDLE) && trig_i;
   assign hi_end = (st_q == ST_HIGH) && tmr_last;

   always_comb begin
      st_d    = st_q;
      tmr_ld  = 1'b0;
      tmr_len = hold_dly_i;
      unique case (st_q)
         ST_IDLE: begin
            if (trig_i) begin
               st_d    = ST_DELAY;
               tmr_ld  = 1'b1;
               tmr_len = hold_dly_i;
            end
         end
         ST_DELAY: begin
            if (tmr_last) begin
               st_d    = ST_LOW;
               tmr_ld  = 1'b1;
               tmr_len = mux_lo_i;
            end
         end
         ST_LOW: begin
            if (tmr_last) begin
               st_d    = ST_HIGH;
               tmr_ld  = 1'b1;
               tmr_len = mux_hi_i;
            end
         end
         ST_HIGH: begin
            if (tmr_last) begin
               tmr_ld = 1'b1;
               if (pcnt_q == LAST_P) begin
                  st_d    = ST_RST;
                  tmr_len = rst_len_i;
               end else begin
                  st_d    = ST_LOW;
                  tmr_len = mux_lo_i;
               end
            end
         end
         ST_RST: begin
            if (tmr_last) begin
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q   <= '0;
         ch_vld_q <= 1'b0;
         ch_idx_q <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         ch_vld_q <= 1'b0;
         done_q   <= 1'b0;
         if (accept) begin
            pcnt_q <= '0;
         end else if (hi_end && (pcnt_q != LAST_P)) begin
            pcnt_q   <= pcnt_q + PW'(1);
            ch_vld_q <= 1'b1;
            ch_idx_q <= pcnt_q[CH_W-1:0];
         end
         if ((st_q == ST_RST) && tmr_last) begin
            done_q <= 1'b1;
            err_q  <= mark_err;
         end
      end
   end

   fe_seq_timer #(.W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_ld),
      .len   (tmr_len),
      .last  (tmr_last)
   );

   fe_seq_marker #(.N_CH(N_CH), .PW(PW)) u_marker (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .smp     (hi_end),
      .pidx    (pcnt_q),
      .srout_i (srout_i),
      .err     (mark_err)
   );

   logic hold_act;
   assign hold_act  = (st_q == ST_LOW) || (st_q == ST_HIGH);
   assign hold_o    = hold_act ? hold_pol_i : ~hold_pol_i;
   assign muxclk_o  = (st_q == ST_HIGH);
   assign vfe_rst_o = (st_q == ST_RST);
   assign busy_o    = (st_q != ST_IDLE);
   assign done_o    = done_q;
   assign err_o     = err_q;
   assign ch_vld_o  = ch_vld_q;
   assign ch_idx_o  = ch_idx_q;

endmodule

// File: rtl/fe_hold_seq_chk.sv
module fe_hold_seq_chk #(
   parameter int N_CH = 36,
   parameter int CH_W = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trig_i,
   input logic            hold_pol_i,
   input logic            hold_o,
   input logic            vfe_rst_o,
   input logic            muxclk_o,
   input logic            busy_o,
   input logic            done_o,
   input logic            ch_vld_o,
   input logic [CH_W-1:0] ch_idx_o
);

   // R1: outside a sequence every chip-side output is quiet
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (hold_o != hold_pol_i) && !muxclk_o && !vfe_rst_o);

   // R3: an idle trigger is taken
   a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && trig_i) |=> busy_o);

   // R4: a low phase with hold already asserted precedes every rising clock
   a_r4_low_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(muxclk_o) |-> $past(hold_o == hold_pol_i) && $past(busy_o));

   // R5: the multiplexer clock only runs under hold
   a_r5_mux_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      muxclk_o |-> (hold_o == hold_pol_i) && busy_o);

   // R6: strobe follows a falling clock edge with a legal index
   a_r6_strobe_edge: assert property (@(posedge clk) disable iff (!rst_n)
      ch_vld_o |-> !muxclk_o && $past(muxclk_o) && (int'(ch_idx_o) < N_CH));

   // R8: reset pulse never overlaps hold or the clock
   a_r8_rst_clear: assert property (@(posedge clk) disable iff (!rst_n)
      vfe_rst_o |-> !muxclk_o && (hold_o != hold_pol_i));

   // R9: completion follows the reset pulse with the block idle
   a_r9_done_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && $past(vfe_rst_o));

endmodule

bind fe_hold_seq fe_hold_seq_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trig_i     (trig_i),
   .hold_pol_i (hold_pol_i),
   .hold_o     (hold_o),
   .vfe_rst_o  (vfe_rst_o),
   .muxclk_o   (muxclk_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .ch_vld_o   (ch_vld_o),
   .ch_idx_o   (ch_idx_o)
);

// File: tb/fe_hold_seq_tb.sv
`timescale 1ns/1ps
module fe_hold_seq_tb;

   localparam int N_CH  = 36;
   localparam int CNT_W = 8;
   localparam int CH_W  = $clog2(N_CH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             trig_i = 1'b0;
   logic             hold_pol_i = 1'b1;
   logic [CNT_W-1:0] hold_dly_i = '0;
   logic [CNT_W-1:0] mux_hi_i = '0;
   logic [CNT_W-1:0] mux_lo_i = '0;
   logic [CNT_W-1:0] rst_len_i = '0;
   logic             srout_i = 1'b0;
   logic             hold_o, vfe_rst_o, muxclk_o, busy_o, done_o, err_o, ch_vld_o;
   logic [CH_W-1:0]  ch_idx_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   fe_hold_seq #(.N_CH(N_CH), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .hold_pol_i(hold_pol_i),
      .hold_dly_i(hold_dly_i), .mux_hi_i(mux_hi_i), .mux_lo_i(mux_lo_i),
      .rst_len_i(rst_len_i), .srout_i(srout_i), .hold_o(hold_o),
      .vfe_rst_o(vfe_rst_o), .muxclk_o(muxclk_o), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o), .ch_vld_o(ch_vld_o), .ch_idx_o(ch_idx_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // mode: 0 correct, 1 early, 2 late, 3 stuck high, 4 absent, 5 stray pulse
   task automatic run_seq(input bit pol, input int dly, input int hi, input int lo,
                          input int rl, input int mode, input bit retrig);
      int d_e, h_e, l_e, r_e, cyc, busy_c, hold_first, hold_c, rise_c, hi_c;
      int strb_c, strb_bad, rst_c, rst_bad, done_c;
      bit prev_mux, done_seen, asserted, prev_err;
      d_e = (dly == 0) ? 1 : dly;
      h_e = (hi == 0) ? 1 : hi;
      l_e = (lo == 0) ? 1 : lo;
      r_e = (rl == 0) ? 1 : rl;
      @(negedge clk);
      hold_pol_i = pol;
      hold_dly_i = CNT_W'(dly);
      mux_hi_i   = CNT_W'(hi);
      mux_lo_i   = CNT_W'(lo);
      rst_len_i  = CNT_W'(rl);
      srout_i    = 1'b0;
      @(negedge clk);
      check("R2", "idle hold level", int'(hold_o), int'(!pol));
      prev_err = err_o;
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
      check("R3", "busy after trigger", int'(busy_o), 1);
      cyc = 0; busy_c = 0; hold_first = -1; hold_c = 0; rise_c = 0; hi_c = 0;
      strb_c = 0; strb_bad = 0; rst_c = 0; rst_bad = 0; done_c = 0;
      prev_mux = 1'b0; done_seen = 1'b0;
      while (!done_seen && cyc < 5000) begin
         if (cyc == 1) check("R9", "verdict kept during run", int'(err_o), int'(prev_err));
         asserted = (hold_o == pol);
         if (busy_o) busy_c++;
         if (done_o) begin
            done_seen = 1'b1;
            done_c++;
            check("R9", "busy low at done", int'(busy_o), 0);
         end
         if (asserted) begin
            hold_c++;
            if (hold_first < 0) hold_first = cyc;
         end
         if (muxclk_o) begin
            hi_c++;
            if (!asserted) rst_bad++;
            if (!prev_mux) begin
               rise_c++;
               case (mode)
                  1: srout_i = (rise_c == N_CH - 1);
                  2: srout_i = (rise_c == N_CH + 1);
                  3: if (rise_c == N_CH) srout_i = 1'b1;
                  4: srout_i = 1'b0;
                  5: srout_i = (rise_c == 5) || (rise_c == N_CH);
                  default: srout_i = (rise_c == N_CH);
               endcase
            end
         end
         if (ch_vld_o) begin
            if (!(prev_mux && !muxclk_o) || int'(ch_idx_o) != strb_c) strb_bad++;
            strb_c++;
         end
         if (vfe_rst_o) begin
            rst_c++;
            if (muxclk_o || asserted) rst_bad++;
         end
         if (retrig && cyc == 20) trig_i = 1'b1;
         if (retrig && cyc == 22) trig_i = 1'b0;
         prev_mux = muxclk_o;
         @(negedge clk);
         cyc++;
      end
      srout_i = 1'b0;
      check("R9", "done seen", int'(done_seen), 1);
      check("R4", "hold delay", hold_first, d_e);
      check("R5", "hold cycles", hold_c, (N_CH + 1) * (l_e + h_e));
      check("R5", "clock pulses", rise_c, N_CH + 1);
      check("R5", "clock high cycles", hi_c, (N_CH + 1) * h_e);
      check("R6", "strobe count", strb_c, N_CH);
      check("R6", "strobe order or placement", strb_bad, 0);
      check("R8", "reset width", rst_c, r_e);
      check("R8", "overlap violations", rst_bad, 0);
      check("R9", "busy length", busy_c, d_e + (N_CH + 1) * (l_e + h_e) + r_e);
      check("R7", "marker verdict", int'(err_o), int'(mode != 0));
      check("R2", "released hold level", int'(hold_o), int'(!pol));
      @(negedge clk);
      check("R9", "done one cycle", int'(done_o), 0);
      check("R9", "verdict held", int'(err_o), int'(mode != 0));
      if (retrig) check("R3", "no second run after ignored trigger", int'(busy_o), 0);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int dlys[3] = '{0, 1, 3};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "busy", int'(busy_o), 0);
      check("R1", "muxclk", int'(muxclk_o), 0);
      check("R1", "reset pulse", int'(vfe_rst_o), 0);
      check("R1", "done", int'(done_o), 0);
      check("R1", "err", int'(err_o), 0);
      check("R1", "strobe", int'(ch_vld_o), 0);
      check("R1", "hold inactive", int'(hold_o), 0);
      hold_pol_i = 1'b0;
      @(negedge clk);
      check("R2", "inverted idle level", int'(hold_o), 1);
      for (int p = 0; p < 2; p++)
         for (int di = 0; di < 3; di++)
            for (int h = 1; h <= 2; h++)
               for (int l = 1; l <= 3; l += 2)
                  for (int r = 0; r <= 2; r += 2)
                     run_seq(p[0], dlys[di], h, l, r, 0, (dlys[di] == 1));
      // R7: marker faults interleaved with clean runs
      for (int m = 1; m <= 5; m++) begin
         run_seq(m[0], 2, 1, 2, 1, m, 1'b0);
         run_seq(!m[0], 1, 2, 1, 0, 0, 1'b0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule